// File: doc/BRIEF.md
# Multi-Destination Transit Branch Pruner

This block sits in the transit path of a switch that carries encapsulated frames over distribution trees. For each frame descriptor it returns a bitmask of the tree branches that should get a copy. Known-unicast descriptors are not inspected: they leave with the branch mask that the next-hop lookup already chose. Multi-destination descriptors are pruned per branch. The decision uses a small associative table that records, for each (branch, label) pair, whether some downstream edge switch is attached and whether multicast listeners or multicast routers sit behind it.

The inner label comes in two 16-bit words. The first word carries a 12-bit high label half together with the transport priority and drop-eligible bit. An extension word, when present, carries the 12-bit low half. A frame is treated as fine-grained when it carries the extension word and its high half lies outside the VLAN-addressable set. That set is the first `cfg_vls_lim_i` label values. Fine-grained frames are matched on all 24 label bits. Plain VLAN frames are matched on the 12-bit high half only. An extension-tagged frame whose high half falls inside the VLAN-addressable set is a configuration conflict. A configuration bit either drops it or handles it as a plain VLAN frame. The result is produced a fixed two cycles after the descriptor is accepted.

Top module: `prune_filter`

## Requirements
- R1: For every descriptor, `prio_o` equals `lbl_hi_i[15:13]` and `dei_o` equals `lbl_hi_i[12]`. Bits [15:12] of `lbl_lo_i` never affect either output.
- R2: A descriptor with `desc_uc_i`=1 yields `fwd_mask_o` = `uc_mask_i` and `drop_o`=0, whatever the table, tree mask, label and conflict setting.
- R3: A fine-grained descriptor (`desc_ext_i`=1 and `lbl_hi_i[11:0]` >= `cfg_vls_lim_i`) hits a branch only through a valid fine-grained entry on that branch whose `label[23:12]` equals `lbl_hi_i[11:0]` and whose `label[11:0]` equals `lbl_lo_i[11:0]`.
- R4: A descriptor with `desc_ext_i`=0 is plain VLAN. It hits a branch only through a valid plain entry on that branch whose `label[23:12]` equals `lbl_hi_i[11:0]`. `lbl_lo_i` is ignored.
- R5: With `desc_mc_i`=1, a branch that hits is forwarded only if at least one hitting entry on it has the listener or router flag set. With `desc_mc_i`=0, a hit alone forwards.
- R6: A branch with no hitting entry is forwarded when `cfg_miss_fwd_i`=1 and pruned when it is 0.
- R7: For multi-destination descriptors, `fwd_mask_o` never has a bit set where `tree_mask_i` is 0.
- R8: An extension-tagged multi-destination descriptor whose high half is below `cfg_vls_lim_i` gives `drop_o`=1 with an all-zero mask when `cfg_vls_drop_i`=1. Otherwise it is pruned as plain VLAN on its high half.
- R9: `res_vld_o` rises exactly two clock cycles after a cycle with `desc_vld_i`=1, one result per descriptor.
- R10: A table write takes effect for descriptors accepted in the following cycle. A descriptor accepted in the same cycle as a write sees the old entry.
- R11: Reset clears all table entries to invalid and holds `res_vld_o`, `fwd_mask_o` and `drop_o` at 0. Whenever `res_vld_o` is 0, the mask and drop outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_vls_lim_i | input | 12 | High-half values below this are VLAN-addressable |
| cfg_vls_drop_i | input | 1 | Drop extension-tagged frames with a VLAN-addressable high half |
| cfg_miss_fwd_i | input | 1 | Forward (1) or prune (0) on a table miss |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_idx_i | input | IDX_W | Entry index to write |
| tbl_vld_i | input | 1 | Entry valid |
| tbl_br_i | input | BR_W | Branch the entry describes |
| tbl_fgl_i | input | 1 | Entry holds a 24-bit label (1) or a 12-bit VLAN (0) |
| tbl_label_i | input | 24 | [23:12] high half, [11:0] low half (fine-grained only) |
| tbl_lis_i | input | 1 | Multicast listener present downstream |
| tbl_rtr_i | input | 1 | Multicast router present downstream |
| desc_vld_i | input | 1 | Frame descriptor valid |
| desc_uc_i | input | 1 | Known-unicast frame |
| desc_ext_i | input | 1 | Extension label word present |
| desc_mc_i | input | 1 | Inner destination is a multicast group |
| lbl_hi_i | input | 16 | First label word: [15:13] priority, [12] DEI, [11:0] high half |
| lbl_lo_i | input | 16 | Extension word: [11:0] low half |
| tree_mask_i | input | N_BR | Branches of the chosen tree |
| uc_mask_i | input | N_BR | Branch mask from the next-hop lookup |
| res_vld_o | output | 1 | Result valid |
| fwd_mask_o | output | N_BR | Branches that receive a copy |
| drop_o | output | 1 | Frame dropped as a label conflict |
| prio_o | output | 3 | Transport priority |
| dei_o | output | 1 | Transport drop-eligible bit |

## Verification
A table write and a lookup can land in the same cycle and touch the same entry. The bench raises an entry's listener flag in exactly the cycle it presents a multicast fine-grained descriptor that matches that entry. The result must show the branch still pruned under the old flags. The next identical descriptor must then show the branch forwarded. The label-conflict path and the unicast bypass can also meet in one descriptor. A unicast frame with a VLAN-addressable high half and the drop enable set must still leave with its next-hop mask and no drop.

// File: rtl/prune_pkg.sv
package prune_pkg;
  localparam int LBL_W  = 12;
  localparam int KEY_W  = 2 * LBL_W;
  localparam int PRIO_HI = 15;
  localparam int PRIO_LO = 13;
  localparam int DEI_BIT = 12;

  typedef enum logic [1:0] {
    KIND_UC  = 2'd0,
    KIND_FGL = 2'd1,
    KIND_VL  = 2'd2,
    KIND_BAD = 2'd3
  } kind_e;

  typedef struct packed {
    logic             vld;
    logic             fgl;
    logic [KEY_W-1:0] label;
    logic             lis;
    logic             rtr;
  } conn_ent_t;
endpackage

// File: rtl/lbl_classify.sv
module lbl_classify
  import prune_pkg::*;
(
  input  logic             uc_i,
  input  logic             ext_i,
  input  logic [15:0]      hi_i,
  input  logic [15:0]      lo_i,
  input  logic [LBL_W-1:0] vls_lim_i,
  input  logic             vls_drop_i,
  output kind_e            kind_o,
  output logic             q_fgl_o,
  output logic [LBL_W-1:0] q_hi_o,
  output logic [LBL_W-1:0] q_lo_o,
  output logic [2:0]       prio_o,
  output logic             dei_o
);
  logic             vls_hit;
  logic [3:0]       unused_lo_top;

  assign unused_lo_top = lo_i[15:12];
  assign q_hi_o  = hi_i[LBL_W-1:0];
  assign q_lo_o  = lo_i[LBL_W-1:0];
  assign vls_hit = (q_hi_o < vls_lim_i);
  // same bit positions for every frame kind
  assign prio_o  = hi_i[PRIO_HI:PRIO_LO];
  assign dei_o   = hi_i[DEI_BIT];

  always_comb begin
    if (uc_i)                       kind_o = KIND_UC;
    else if (ext_i && !vls_hit)     kind_o = KIND_FGL;
    else if (ext_i && vls_drop_i)   kind_o = KIND_BAD;
    else                            kind_o = KIND_VL;
  end

  assign q_fgl_o = (kind_o == KIND_FGL);
endmodule

// File: rtl/conn_table.sv
module conn_table
  import prune_pkg::*;
#(
  parameter  int N_BR  = 4,
  parameter  int N_ENT = 16,
  localparam int BR_W  = (N_BR  > 1) ? $clog2(N_BR)  : 1,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  conn_ent_t        ent_i,
  input  logic [BR_W-1:0]  br_i,
  input  logic             q_fgl_i,
  input  logic [LBL_W-1:0] q_hi_i,
  input  logic [LBL_W-1:0] q_lo_i,
  output logic [N_BR-1:0]  hit_o,
  output logic [N_BR-1:0]  flag_o
);
  conn_ent_t       ents [N_ENT];
  logic [BR_W-1:0] brs  [N_ENT];
  logic [N_ENT-1:0] key_eq;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ents[e] <= '0;
        brs[e]  <= '0;
      end else if (we_i && (idx_i == IDX_W'(e))) begin
        ents[e] <= ent_i;
        brs[e]  <= br_i;
      end
    end

    // 24-bit compare for fine-grained, high half only for plain entries
    assign key_eq[e] = ents[e].vld
                     && (ents[e].label[KEY_W-1:LBL_W] == q_hi_i)
                     && (q_fgl_i ? (ents[e].fgl && ents[e].label[LBL_W-1:0] == q_lo_i)
                                 : !ents[e].fgl);
  end

  for (genvar b = 0; b < N_BR; b++) begin : g_br
    always_comb begin
      hit_o[b]  = 1'b0;
      flag_o[b] = 1'b0;
      for (int e = 0; e < N_ENT; e++) begin
        if (key_eq[e] && (brs[e] == BR_W'(b))) begin
          hit_o[b]  = 1'b1;
          flag_o[b] = flag_o[b] | ents[e].lis | ents[e].rtr;
        end
      end
    end
  end
endmodule

// File: rtl/prune_mask.sv
module prune_mask
  import prune_pkg::*;
#(
  parameter int N_BR = 4
) (
  input  kind_e           kind_i,
  input  logic            mc_i,
  input  logic            miss_fwd_i,
  input  logic [N_BR-1:0] hit_i,
  input  logic [N_BR-1:0] flag_i,
  input  logic [N_BR-1:0] tree_i,
  input  logic [N_BR-1:0] ucm_i,
  output logic [N_BR-1:0] mask_o,
  output logic            drop_o
);
  logic [N_BR-1:0] sel;

  for (genvar b = 0; b < N_BR; b++) begin : g_sel
    assign sel[b] = hit_i[b] ? (mc_i ? flag_i[b] : 1'b1) : miss_fwd_i;
  end

  always_comb begin
    drop_o = 1'b0;
    unique case (kind_i)
      KIND_UC:  mask_o = ucm_i;
      KIND_BAD: begin
        mask_o = '0;
        drop_o = 1'b1;
      end
      default:  mask_o = sel & tree_i;
    endcase
  end
endmodule

// File: rtl/prune_filter.sv
module prune_filter
  import prune_pkg::*;
#(
  parameter  int N_BR  = 4,
  parameter  int N_ENT = 16,
  localparam int BR_W  = (N_BR  > 1) ? $clog2(N_BR)  : 1,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [11:0]      cfg_vls_lim_i,
  input  logic             cfg_vls_drop_i,
  input  logic             cfg_miss_fwd_i,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_idx_i,
  input  logic             tbl_vld_i,
  input  logic [BR_W-1:0]  tbl_br_i,
  input  logic             tbl_fgl_i,
  input  logic [23:0]      tbl_label_i,
  input  logic             tbl_lis_i,
  input  logic             tbl_rtr_i,
  input  logic             desc_vld_i,
  input  logic             desc_uc_i,
  input  logic             desc_ext_i,
  input  logic             desc_mc_i,
  input  logic [15:0]      lbl_hi_i,
  input  logic [15:0]      lbl_lo_i,
  input  logic [N_BR-1:0]  tree_mask_i,
  input  logic [N_BR-1:0]  uc_mask_i,
  output logic             res_vld_o,
  output logic [N_BR-1:0]  fwd_mask_o,
  output logic             drop_o,
  output logic [2:0]       prio_o,
  output logic             dei_o
);
  kind_e            c_kind;
  logic             c_fgl;
  logic [LBL_W-1:0] c_hi, c_lo;
  logic [2:0]       c_prio;
  logic             c_dei;
  logic [N_BR-1:0]  c_hit, c_flag;
  conn_ent_t        wr_ent;

  lbl_classify i_classify (
    .uc_i       (desc_uc_i),
    .ext_i      (desc_ext_i),
    .hi_i       (lbl_hi_i),
    .lo_i       (lbl_lo_i),
    .vls_lim_i  (cfg_vls_lim_i),
    .vls_drop_i (cfg_vls_drop_i),
    .kind_o     (c_kind),
    .q_fgl_o    (c_fgl),
    .q_hi_o     (c_hi),
    .q_lo_o     (c_lo),
    .prio_o     (c_prio),
    .dei_o      (c_dei)
  );

  assign wr_ent = '{vld: tbl_vld_i, fgl: tbl_fgl_i, label: tbl_label_i,
                    lis: tbl_lis_i, rtr: tbl_rtr_i};

  conn_table #(.N_BR(N_BR), .N_ENT(N_ENT)) i_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .idx_i   (tbl_idx_i),
    .ent_i   (wr_ent),
    .br_i    (tbl_br_i),
    .q_fgl_i (c_fgl),
    .q_hi_i  (c_hi),
    .q_lo_i  (c_lo),
    .hit_o   (c_hit),
    .flag_o  (c_flag)
  );

  // stage 1: lookup result and descriptor context
  logic            s1_vld, s1_mc, s1_miss, s1_dei;
  kind_e           s1_kind;
  logic [2:0]      s1_prio;
  logic [N_BR-1:0] s1_hit, s1_flag, s1_tree, s1_ucm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_mc   <= 1'b0;
      s1_miss <= 1'b0;
      s1_dei  <= 1'b0;
      s1_kind <= KIND_UC;
      s1_prio <= '0;
      s1_hit  <= '0;
      s1_flag <= '0;
      s1_tree <= '0;
      s1_ucm  <= '0;
    end else begin
      s1_vld <= desc_vld_i;
      if (desc_vld_i) begin
        s1_mc   <= desc_mc_i;
        s1_miss <= cfg_miss_fwd_i;
        s1_dei  <= c_dei;
        s1_kind <= c_kind;
        s1_prio <= c_prio;
        s1_hit  <= c_hit;
        s1_flag <= c_flag;
        s1_tree <= tree_mask_i;
        s1_ucm  <= uc_mask_i;
      end
    end
  end

  logic [N_BR-1:0] m_mask;
  logic            m_drop;

  prune_mask #(.N_BR(N_BR)) i_mask (
    .kind_i     (s1_kind),
    .mc_i       (s1_mc),
    .miss_fwd_i (s1_miss),
    .hit_i      (s1_hit),
    .flag_i     (s1_flag),
    .tree_i     (s1_tree),
    .ucm_i      (s1_ucm),
    .mask_o     (m_mask),
    .drop_o     (m_drop)
  );

  // stage 2: outputs, zeroed when idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o  <= 1'b0;
      fwd_mask_o <= '0;
      drop_o     <= 1'b0;
      prio_o     <= '0;
      dei_o      <= 1'b0;
    end else begin
      res_vld_o  <= s1_vld;
      fwd_mask_o <= s1_vld ? m_mask : '0;
      drop_o     <= s1_vld & m_drop;
      prio_o     <= s1_vld ? s1_prio : '0;
      dei_o      <= s1_vld & s1_dei;
    end
  end
endmodule

// File: rtl/prune_filter_chk.sv
module prune_filter_chk #(
  parameter int N_BR = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [11:0]     cfg_vls_lim_i,
  input logic            cfg_vls_drop_i,
  input logic            desc_vld_i,
  input logic            desc_uc_i,
  input logic            desc_ext_i,
  input logic [15:0]     lbl_hi_i,
  input logic [N_BR-1:0] tree_mask_i,
  input logic [N_BR-1:0] uc_mask_i,
  input logic            res_vld_o,
  input logic [N_BR-1:0] fwd_mask_o,
  input logic            drop_o,
  input logic [2:0]      prio_o,
  input logic            dei_o
);
  logic [1:0]      cnt;
  logic            d1_vld, d2_vld, d1_uc, d2_uc, d1_bad, d2_bad;
  logic [3:0]      d1_pd, d2_pd;
  logic [N_BR-1:0] d1_tree, d2_tree, d1_ucm, d2_ucm;
  logic            in_bad;

  assign in_bad = !desc_uc_i && desc_ext_i && cfg_vls_drop_i
                  && (lbl_hi_i[11:0] < cfg_vls_lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0;
      {d1_vld, d2_vld, d1_uc, d2_uc, d1_bad, d2_bad} <= '0;
      {d1_pd, d2_pd} <= '0;
      {d1_tree, d2_tree, d1_ucm, d2_ucm} <= '0;
    end else begin
      if (cnt != 2'd2) cnt <= cnt + 2'd1;
      d1_vld <= desc_vld_i;   d2_vld <= d1_vld;
      d1_uc  <= desc_uc_i;    d2_uc  <= d1_uc;
      d1_bad <= in_bad;       d2_bad <= d1_bad;
      d1_pd  <= lbl_hi_i[15:12]; d2_pd <= d1_pd;
      d1_tree <= tree_mask_i; d2_tree <= d1_tree;
      d1_ucm <= uc_mask_i;    d2_ucm <= d1_ucm;
    end
  end

  // R9
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd2) |-> (res_vld_o == d2_vld));

  // R1
  prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd2 && res_vld_o) |-> (prio_o == d2_pd[3:1] && dei_o == d2_pd[0]));

  // R2
  ucast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd2 && res_vld_o && d2_uc) |-> (fwd_mask_o == d2_ucm && !drop_o));

  // R7
  tree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd2 && res_vld_o && !d2_uc) |-> ((fwd_mask_o & ~d2_tree) == '0));

  // R8
  vls_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd2 && res_vld_o && d2_bad) |-> (drop_o && fwd_mask_o == '0));

  // R11
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> (fwd_mask_o == '0 && !drop_o));
endmodule

bind prune_filter prune_filter_chk #(.N_BR(N_BR)) i_prune_filter_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_vls_lim_i  (cfg_vls_lim_i),
  .cfg_vls_drop_i (cfg_vls_drop_i),
  .desc_vld_i     (desc_vld_i),
  .desc_uc_i      (desc_uc_i),
  .desc_ext_i     (desc_ext_i),
  .lbl_hi_i       (lbl_hi_i),
  .tree_mask_i    (tree_mask_i),
  .uc_mask_i      (uc_mask_i),
  .res_vld_o      (res_vld_o),
  .fwd_mask_o     (fwd_mask_o),
  .drop_o         (drop_o),
  .prio_o         (prio_o),
  .dei_o          (dei_o)
);

// File: tb/test_prune_filter.sv
`timescale 1ns/1ps
module test_prune_filter;
  localparam int N_BR  = 4;
  localparam int N_ENT = 16;

  typedef struct packed {
    logic        uc, ext, mc, miss, vdrop;
    logic [11:0] x, y;
    logic [3:0]  pd, tree, ucm, em;
    logic        ed;
  } vec_t;

  // uc ext mc miss vdrop  x  y  pd tree ucm exp_mask exp_drop
  localparam vec_t VECS [14] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,12'h100,12'h005,4'hA,4'hF,4'h0,4'h3,1'b0}, // R3
    '{1'b0,1'b1,1'b1,1'b0,1'b0,12'h100,12'h005,4'h5,4'hF,4'h0,4'h1,1'b0}, // R5
    '{1'b0,1'b1,1'b0,1'b1,1'b0,12'h100,12'h005,4'h3,4'hF,4'h0,4'hF,1'b0}, // R6
    '{1'b0,1'b1,1'b1,1'b0,1'b0,12'h100,12'h006,4'hE,4'hF,4'h0,4'h4,1'b0}, // R3
    '{1'b0,1'b1,1'b0,1'b0,1'b0,12'h100,12'h005,4'h1,4'h5,4'h0,4'h1,1'b0}, // R7
    '{1'b0,1'b0,1'b0,1'b0,1'b0,12'h100,12'h005,4'h8,4'hF,4'h0,4'h2,1'b0}, // R4
    '{1'b0,1'b0,1'b1,1'b0,1'b0,12'h100,12'h000,4'h6,4'hF,4'h0,4'h2,1'b0}, // R5
    '{1'b0,1'b0,1'b1,1'b0,1'b0,12'h00A,12'h000,4'h9,4'hF,4'h0,4'h8,1'b0}, // R5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,12'h00A,12'h000,4'h2,4'hF,4'h0,4'hC,1'b0}, // R4
    '{1'b0,1'b1,1'b0,1'b1,1'b1,12'h00A,12'h005,4'h7,4'hF,4'h0,4'h0,1'b1}, // R8
    '{1'b0,1'b1,1'b0,1'b0,1'b0,12'h00A,12'h005,4'hB,4'hF,4'h0,4'hC,1'b0}, // R8
    '{1'b1,1'b1,1'b1,1'b0,1'b0,12'h100,12'h005,4'h4,4'h0,4'hA,4'hA,1'b0}, // R2
    '{1'b1,1'b1,1'b0,1'b0,1'b1,12'h00A,12'h005,4'hD,4'hF,4'h6,4'h6,1'b0}, // R2
    '{1'b0,1'b1,1'b0,1'b1,1'b0,12'h200,12'h001,4'hF,4'hB,4'h0,4'hB,1'b0}  // R6
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [11:0] cfg_vls_lim_i = 12'd16;
  logic cfg_vls_drop_i = 1'b0, cfg_miss_fwd_i = 1'b0;
  logic tbl_we_i = 1'b0, tbl_vld_i = 1'b0, tbl_fgl_i = 1'b0, tbl_lis_i = 1'b0, tbl_rtr_i = 1'b0;
  logic [3:0] tbl_idx_i = '0;
  logic [1:0] tbl_br_i = '0;
  logic [23:0] tbl_label_i = '0;
  logic desc_vld_i = 1'b0, desc_uc_i = 1'b0, desc_ext_i = 1'b0, desc_mc_i = 1'b0;
  logic [15:0] lbl_hi_i = '0, lbl_lo_i = '0;
  logic [N_BR-1:0] tree_mask_i = '0, uc_mask_i = '0;
  logic res_vld_o, drop_o, dei_o;
  logic [N_BR-1:0] fwd_mask_o;
  logic [2:0] prio_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  prune_filter #(.N_BR(N_BR), .N_ENT(N_ENT)) i_prune_filter (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, bit v, int br, bit fgl, logic [23:0] lbl, bit lis, bit rtr);
    @(negedge clk_i);
    tbl_we_i = 1'b1; tbl_idx_i = 4'(idx); tbl_vld_i = v; tbl_br_i = 2'(br);
    tbl_fgl_i = fgl; tbl_label_i = lbl; tbl_lis_i = lis; tbl_rtr_i = rtr;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  task automatic drive(vec_t v);
    desc_vld_i = 1'b1; desc_uc_i = v.uc; desc_ext_i = v.ext; desc_mc_i = v.mc;
    cfg_miss_fwd_i = v.miss; cfg_vls_drop_i = v.vdrop;
    lbl_hi_i = {v.pd, v.x}; lbl_lo_i = {~v.pd, v.y};
    tree_mask_i = v.tree; uc_mask_i = v.ucm;
  endtask

  // drive at a negedge, result is sampled two edges later
  task automatic send(vec_t v, string req);
    @(negedge clk_i);
    drive(v);
    @(negedge clk_i);
    desc_vld_i = 1'b0;
    check("R9 one edge", 32'(res_vld_o), 32'd0);
    @(negedge clk_i);
    check("R9 two edges", 32'(res_vld_o), 32'd1);
    check({req, " mask"}, 32'(fwd_mask_o), 32'(v.em));
    check({req, " drop"}, 32'(drop_o), 32'(v.ed));
    check("R1 prio/dei", 32'({prio_o, dei_o}), 32'(v.pd));
  endtask

  task automatic load_table();
    wr(0, 1, 0, 1, 24'h100005, 1, 0);
    wr(1, 1, 1, 1, 24'h100005, 0, 0);
    wr(2, 1, 2, 1, 24'h100006, 1, 1);
    wr(3, 1, 1, 0, 24'h100000, 0, 1);
    wr(4, 1, 3, 0, 24'h00A000, 1, 0);
    wr(5, 1, 2, 0, 24'h00A000, 0, 0);
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11 vld in reset", 32'(res_vld_o), 32'd0);
    check("R11 mask in reset", 32'(fwd_mask_o), 32'd0);
    check("R11 drop in reset", 32'(drop_o), 32'd0);
    rst_ni = 1'b1;
    load_table();

    foreach (VECS[i]) send(VECS[i], $sformatf("vec%0d", i));

    // R10: write entry 1 (listener on) in the lookup cycle: old entry used
    v = VECS[1];
    @(negedge clk_i);
    drive(v);
    tbl_we_i = 1'b1; tbl_idx_i = 4'd1; tbl_vld_i = 1'b1; tbl_br_i = 2'd1;
    tbl_fgl_i = 1'b1; tbl_label_i = 24'h100005; tbl_lis_i = 1'b1; tbl_rtr_i = 1'b0;
    @(negedge clk_i);
    desc_vld_i = 1'b0; tbl_we_i = 1'b0;
    @(negedge clk_i);
    check("R10 same-cycle write", 32'(fwd_mask_o), 32'h1);
    v.em = 4'h3;
    send(v, "R10 after write");

    // R11 table cleared by reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R11 vld after reset", 32'(res_vld_o), 32'd0);
    rst_ni = 1'b1;
    v = VECS[0];           // would hit branches 0,1 with a loaded table
    v.em = 4'h0;
    send(v, "R11 cleared miss-prune");
    v.miss = 1'b1; v.em = 4'hF;
    send(v, "R11 cleared miss-fwd");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule